// File: doc/BRIEF.md
# Colour Lookup Table Write Port

This block holds a 256-entry colour lookup table of red, green and blue triplets and gives a host a narrow byte-wide register path for loading it. The host first sets a starting entry through an index register. It then streams colour bytes through one data register. An internal component counter walks red, green and blue. After blue it moves on to the next entry, so a whole palette can be loaded with one index write followed by a run of data writes.

Each component is a full 8-bit value. Whenever a data write changes the byte it replaces, the block issues a redraw request, because a palette change alters every visible pixel. The request appears both as a one-cycle pulse and as a sticky flag, which the display side clears. A separate read port, addressed by pixel value, returns the full 24-bit colour of any entry to the pixel pipeline. This read port runs independently of the register path.

Top module: `pal_dac_wport`

## Requirements
- R1: After synchronous reset the entry index and component counter are 0, `redraw_pulse` and `redraw_pending` are 0, and `bus_rdata` is 0. Table contents are not reset.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1) at window offset 0x08 loads the entry index from `bus_wdata` and returns the component counter to red, even if a triplet was only partly written.
- R3: A bus read (`bus_sel`=1, `bus_wr`=0) at offset 0x08 presents the current entry index on `bus_rdata` one clock edge later.
- R4: A bus write at offset 0x09 stores `bus_wdata` into the current entry at the component selected by the counter: 0 is red, 1 is green and 2 is blue.
- R5: Each data write advances the counter. The write that stores blue returns the counter to red and increments the entry index by one, and index 255 wraps to 0.
- R6: The pixel port returns `pix_rgb` = {red[23:16], green[15:8], blue[7:0]} of entry `pix_idx` one clock edge after `pix_idx` is sampled.
- R7: A data write whose byte differs from the stored byte raises `redraw_pulse` for one cycle, two clock edges after the write. A write of an identical byte raises nothing.
- R8: `redraw_pending` is set together with every `redraw_pulse` and stays set until `redraw_clr` is sampled high. A new change on the same edge wins over the clear.
- R9: A bus read at offset 0x09 returns 0 and does not move the counter or the index. Writes to other offsets in the window change neither the table nor the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Offset within the 32-byte register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pix_idx | input | 8 | Pixel value used as the table index |
| pix_rgb | output | 24 | Registered colour of entry `pix_idx` |
| redraw_clr | input | 1 | Clears the sticky redraw flag |
| redraw_pulse | output | 1 | One-cycle full-screen redraw request |
| redraw_pending | output | 1 | Sticky redraw request |

## Verification
Register reads and pixel lookups are due one edge after the access is sampled, and a table write is visible to a pixel lookup sampled on the next edge. The redraw pulse and the setting of the sticky flag are due two edges after the data write, because the old byte is read and compared in a registered stage first. The bench drives every input on the falling edge and samples results on the following falling edges. For redraw checks it waits exactly one extra falling edge after the write, so each result is taken in the one cycle in which it is due.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  localparam int NCOMP = 3;
endpackage

// File: rtl/pal_ptr.sv
`timescale 1ns/1ps
module pal_ptr
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output comp_e            sub
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      sub <= COMP_R;
    end else if (load) begin
      idx <= load_val;
      sub <= COMP_R;
    end else if (step) begin
      case (sub)
        COMP_R:  sub <= COMP_G;
        COMP_G:  sub <= COMP_B;
        default: begin
          sub <= COMP_R;
          idx <= idx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pal_bank.sv
`timescale 1ns/1ps
module pal_bank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] wq,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // port A: write with read-first old value
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    wq <= mem[wa];
  end

  // port B: pixel lookup
  always_ff @(posedge clk) begin
    rq <= mem[ra];
  end
endmodule

// File: rtl/pal_chg.sv
`timescale 1ns/1ps
module pal_chg
  import pal_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  comp_e             comp,
  input  logic [DW-1:0]     new_val,
  input  logic [NCOMP*DW-1:0] old_vals,
  input  logic              clr,
  output logic              pulse,
  output logic              pending
);
  logic          wr_q;
  comp_e         comp_q;
  logic [DW-1:0] new_q;
  logic [DW-1:0] old_sel;
  logic          diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      comp_q <= COMP_R;
      new_q  <= '0;
    end else begin
      wr_q   <= wr;
      comp_q <= comp;
      new_q  <= new_val;
    end
  end

  always_comb begin
    case (comp_q)
      COMP_R:  old_sel = old_vals[3*DW-1:2*DW];
      COMP_G:  old_sel = old_vals[2*DW-1:DW];
      default: old_sel = old_vals[DW-1:0];
    endcase
  end

  assign diff = wr_q && (old_sel != new_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse   <= 1'b0;
      pending <= 1'b0;
    end else begin
      pulse   <= diff;
      pending <= (pending && !clr) || diff;
    end
  end
endmodule

// File: rtl/pal_dac_wport.sv
`timescale 1ns/1ps
module pal_dac_wport
  import pal_pkg::*;
#(
  parameter int WIN_W  = 5,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [WIN_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [IDX_W-1:0]        pix_idx,
  output logic [NCOMP*COMP_W-1:0] pix_rgb,
  input  logic                    redraw_clr,
  output logic                    redraw_pulse,
  output logic                    redraw_pending
);
  localparam logic [WIN_W-1:0] OFF_INDEX = WIN_W'(8'h08);
  localparam logic [WIN_W-1:0] OFF_COLOR = WIN_W'(8'h09);
  localparam int RGB_W = NCOMP * COMP_W;

  logic             hit_idx_wr;
  logic             hit_col_wr;
  logic             hit_rd;
  logic [IDX_W-1:0] ptr_idx;
  comp_e            ptr_sub;
  logic [RGB_W-1:0] old_vals;

  assign hit_idx_wr = bus_sel && bus_wr && (bus_addr == OFF_INDEX);
  assign hit_col_wr = bus_sel && bus_wr && (bus_addr == OFF_COLOR);
  assign hit_rd     = bus_sel && !bus_wr;

  pal_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (hit_idx_wr),
    .load_val (IDX_W'(bus_wdata)),
    .step     (hit_col_wr),
    .idx      (ptr_idx),
    .sub      (ptr_sub)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_bank
    localparam int LSB = (NCOMP - 1 - c) * COMP_W;
    logic bank_we;
    assign bank_we = hit_col_wr && (ptr_sub == comp_e'(c));
    pal_bank #(.AW(IDX_W), .DW(COMP_W)) u_bank (
      .clk (clk),
      .we  (bank_we),
      .wa  (ptr_idx),
      .wd  (COMP_W'(bus_wdata)),
      .wq  (old_vals[LSB +: COMP_W]),
      .ra  (pix_idx),
      .rq  (pix_rgb[LSB +: COMP_W])
    );
  end

  pal_chg #(.DW(COMP_W)) u_chg (
    .clk      (clk),
    .rst      (rst),
    .wr       (hit_col_wr),
    .comp     (ptr_sub),
    .new_val  (COMP_W'(bus_wdata)),
    .old_vals (old_vals),
    .clr      (redraw_clr),
    .pulse    (redraw_pulse),
    .pending  (redraw_pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (hit_rd) begin
      if (bus_addr == OFF_INDEX) bus_rdata <= DATA_W'(ptr_idx);
      else                       bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/pal_dac_wport_chk.sv
`timescale 1ns/1ps
module pal_dac_wport_chk
  import pal_pkg::*;
#(
  parameter int WIN_W  = 5,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [WIN_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              redraw_clr,
  input logic              redraw_pulse,
  input logic              redraw_pending,
  input logic [IDX_W-1:0]  ptr_idx,
  input comp_e             ptr_sub
);
  localparam logic [WIN_W-1:0] A_IDX = WIN_W'(8'h08);
  localparam logic [WIN_W-1:0] A_COL = WIN_W'(8'h09);

  p_idx_read_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == A_IDX) |=> (bus_rdata == DATA_W'($past(ptr_idx))));

  p_col_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == A_COL) |=> (bus_rdata == '0));

  p_sub_range_r5: assert property (@(posedge clk) disable iff (rst)
    ptr_sub != comp_e'(2'd3));

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (rst)
    redraw_pulse |-> $past(bus_sel && bus_wr && bus_addr == A_COL, 2));

  p_pending_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    redraw_pulse |-> redraw_pending);

  p_pending_clear_r8: assert property (@(posedge clk) disable iff (rst)
    redraw_clr |=> (!redraw_pending || redraw_pulse));

  p_idx_load_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == A_IDX) |=> (ptr_sub == COMP_R));
endmodule

bind pal_dac_wport pal_dac_wport_chk #(
  .WIN_W(WIN_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_sel        (bus_sel),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .bus_rdata      (bus_rdata),
  .redraw_clr     (redraw_clr),
  .redraw_pulse   (redraw_pulse),
  .redraw_pending (redraw_pending),
  .ptr_idx        (ptr_idx),
  .ptr_sub        (ptr_sub)
);

// File: tb/pal_dac_wport_test.sv
`timescale 1ns/1ps
module pal_dac_wport_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic        redraw_clr = 1'b0;
  logic        redraw_pulse;
  logic        redraw_pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pal_dac_wport uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb), .redraw_clr(redraw_clr),
    .redraw_pulse(redraw_pulse), .redraw_pending(redraw_pending)
  );

  localparam logic [4:0] A_IDX = 5'h08;
  localparam logic [4:0] A_COL = 5'h09;

  // {entry, red, green, blue}
  localparam logic [31:0] VEC [0:5] = '{
    32'h01_112233, 32'h02_A0B0C0, 32'h7F_FFFFFF,
    32'h80_000000, 32'hC3_5A6B7C, 32'h04_010203
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic look(input logic [7:0] i, output logic [23:0] c);
    @(negedge clk);
    pix_idx = i;
    @(negedge clk);
    c = pix_rgb;
  endtask

  task automatic clear_flag();
    @(negedge clk); @(negedge clk); @(negedge clk);
    redraw_clr = 1'b1;
    @(negedge clk);
    redraw_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [23:0] rgb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pulse", {31'd0, redraw_pulse}, 32'd0);
    chk("R1 pending", {31'd0, redraw_pending}, 32'd0);
    chk("R1 rdata", {24'd0, bus_rdata}, 32'd0);
    rd_reg(A_IDX, rd);
    chk("R1 index", {24'd0, rd}, 32'd0);

    // table walk: R2 load, R4 store, R5 advance, R6 lookup
    for (int k = 0; k < 6; k++) begin
      wr_reg(A_IDX, VEC[k][31:24]);
      wr_reg(A_COL, VEC[k][23:16]);
      wr_reg(A_COL, VEC[k][15:8]);
      wr_reg(A_COL, VEC[k][7:0]);
      rd_reg(A_IDX, rd);
      chk("R5 index advance", {24'd0, rd}, {24'd0, VEC[k][31:24] + 8'd1});
    end
    for (int k = 0; k < 6; k++) begin
      look(VEC[k][31:24], rgb);
      chk("R4 R6 lookup", {8'd0, rgb}, {8'd0, VEC[k][23:0]});
    end

    // R2 partial triplet then reload
    wr_reg(A_IDX, 8'h10);
    wr_reg(A_COL, 8'hAA);
    rd_reg(A_IDX, rd);
    chk("R2 index held mid-triplet", {24'd0, rd}, 32'h10);
    wr_reg(A_IDX, 8'h10);
    wr_reg(A_COL, 8'h44); wr_reg(A_COL, 8'h55); wr_reg(A_COL, 8'h66);
    look(8'h10, rgb);
    chk("R2 counter reset on load", {8'd0, rgb}, 32'h445566);

    // R5 wrap 255 -> 0
    wr_reg(A_IDX, 8'hFF);
    wr_reg(A_COL, 8'h9A); wr_reg(A_COL, 8'h9B); wr_reg(A_COL, 8'h9C);
    wr_reg(A_COL, 8'h0D); wr_reg(A_COL, 8'h0E); wr_reg(A_COL, 8'h0F);
    look(8'hFF, rgb);
    chk("R5 entry 255", {8'd0, rgb}, 32'h9A9B9C);
    look(8'h00, rgb);
    chk("R5 wrapped entry 0", {8'd0, rgb}, 32'h0D0E0F);
    rd_reg(A_IDX, rd);
    chk("R5 index after wrap", {24'd0, rd}, 32'h01);

    // R9 data read returns 0, does not advance; other offset ignored
    wr_reg(A_IDX, 8'h30);
    wr_reg(A_COL, 8'h01);
    rd_reg(A_COL, rd);
    chk("R9 data read zero", {24'd0, rd}, 32'd0);
    wr_reg(A_COL, 8'h02);
    wr_reg(5'h0A, 8'hEE);
    wr_reg(A_COL, 8'h03);
    look(8'h30, rgb);
    chk("R9 no advance / offset ignored", {8'd0, rgb}, 32'h010203);
    rd_reg(A_IDX, rd);
    chk("R9 index unaffected", {24'd0, rd}, 32'h31);

    // R7 / R8 redraw behaviour on entry 0x40
    wr_reg(A_IDX, 8'h40);
    wr_reg(A_COL, 8'h10); wr_reg(A_COL, 8'h20); wr_reg(A_COL, 8'h30);
    clear_flag();
    chk("R8 cleared", {31'd0, redraw_pending}, 32'd0);
    wr_reg(A_IDX, 8'h40);
    wr_reg(A_COL, 8'h10);           // same red
    @(negedge clk);
    chk("R7 same value no pulse", {31'd0, redraw_pulse}, 32'd0);
    chk("R7 same value no pending", {31'd0, redraw_pending}, 32'd0);
    wr_reg(A_COL, 8'h21);           // green changes
    @(negedge clk);
    chk("R7 pulse on change", {31'd0, redraw_pulse}, 32'd1);
    chk("R8 pending set", {31'd0, redraw_pending}, 32'd1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, redraw_pulse}, 32'd0);
    chk("R8 pending sticky", {31'd0, redraw_pending}, 32'd1);
    redraw_clr = 1'b1;
    @(negedge clk);
    redraw_clr = 1'b0;
    chk("R8 clear", {31'd0, redraw_pending}, 32'd0);

    // R8 set wins over clear on the same edge
    wr_reg(A_COL, 8'h31);           // blue changes
    redraw_clr = 1'b1;
    @(negedge clk);
    redraw_clr = 1'b0;
    chk("R8 set beats clear", {31'd0, redraw_pending}, 32'd1);
    look(8'h40, rgb);
    chk("R4 rewritten entry", {8'd0, rgb}, 32'h102131);

    // R1 reset again mid-run
    clear_flag();
    wr_reg(A_IDX, 8'h55);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_reg(A_IDX, rd);
    chk("R1 index after reset", {24'd0, rd}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule